// File: doc/BRIEF.md
# Modem Status Scanner Controller

This block watches the modem-status inputs of a group of serial lines (ring indicate, carrier detect, clear to send, secondary receive) and drives each line's modem-control outputs (line enable, data terminal ready, request to send, secondary transmit). A scan engine steps through the lines, one per clock. It compares each line's four inputs with a stored copy of their last known values. On the first mismatch it updates the copy, stops, and records in the control/status word which line changed and which signals changed. If interrupts are enabled, it raises an interrupt.

Software reaches the block through a single 16-bit register port with two addresses: a control/status word and a line status word. Before it selects a line and touches its line status word, software clears scan enable and waits for busy to read 0. After it has serviced a report, software writes interrupt enable and scan enable together. This clears the report and resumes scanning at the line after the one that was reported. A maintenance setting loops each line's control outputs back onto its status inputs, so the block can test itself without modems attached.

Top module: `mdm_scan_ctrl`

## Requirements
- R1: After reset, the control/status word reads 0x0000, irq_o is 0, every line output is 0, and the line status word of line 0 reads 0x0000 when all inputs are 0.
- R2: While scan enable (bit 5) is 1 and done (bit 7) is 0, the scanner compares one line per clock, in increasing line order, starting at line 0 after reset. On a mismatch it sets done, puts the line number in bits 3:0, and sets one flag per changed input: bit 15 ring, 14 carrier, 13 clear to send, 12 secondary receive. Done, flags and line number then hold until the next control/status write.
- R3: irq_o is 1 exactly when done is 1 and interrupt enable (bit 6) is 1.
- R4: A control/status write with bits 6 and 5 both set resumes scanning. Scanning continues from the line after the last one compared, so two lines that change together are reported one after the other, lowest line first after a scan clear.
- R5: Busy (bit 4) reads 1 while scanning is enabled and no report is pending. It reads 0 from the second clock edge after the write that clears scan enable.
- R6: A control/status write loads the selected line from bits 3:0. A line status write then stores bit 0 line enable, bit 1 DTR, bit 2 RTS and bit 3 secondary transmit into that line's outputs only.
- R7: A line status read returns, for the selected line, bit 7 ring, bit 6 carrier, bit 5 clear to send and bit 4 secondary receive, plus the four stored control bits in bits 3:0.
- R8: A control/status write with bits 7 and 6 set (and bits 11 and 10 clear) sets done and raises irq_o, so interrupt wiring can be probed.
- R9: A control/status write with bit 10 set clears every line's outputs and every stored input copy, clears done, and returns the scan position to line 0.
- R10: With maintenance (bit 9) set, each line's carrier, clear to send and secondary receive inputs are taken from its own DTR, RTS and secondary transmit outputs, and ring reads 0. The input pins are ignored by both the scanner and line status reads.
- R11: A control/status write with step (bit 8) set and scan enable clear makes the scanner compare exactly one line and advance by one.
- R12: Any other control/status write loads done from bit 7 and clears the four change flags. Bit 11 also returns the scan position to line 0.
- R13: With scan enable clear and no step pending, changes on the input pins never set done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_sel_lsr | input | 1 | Register select: 0 control/status word, 1 line status word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| ring_i | input | N_LINES | Per-line ring indicate |
| car_i | input | N_LINES | Per-line carrier detect |
| cts_i | input | N_LINES | Per-line clear to send |
| sr_i | input | N_LINES | Per-line secondary receive |
| le_o | output | N_LINES | Per-line line enable |
| dtr_o | output | N_LINES | Per-line data terminal ready |
| rts_o | output | N_LINES | Per-line request to send |
| st_o | output | N_LINES | Per-line secondary transmit |
| irq_o | output | 1 | Interrupt request, level |

## Verification
Register writes take effect on the clock edge that samples the strobe, and line outputs and read data change at that same edge. Busy lags scan enable by one further edge, so the bench checks it at one and at two edges after the write. A change on line k is compared at the (k+1)-th edge after the write that enables scanning from line 0, so done and irq_o appear there. The bench samples the edge just before and the edge just after, and checks that the first reads 0 and the second reads 1. Other reports arrive within N_LINES+1 edges. The scoreboard's monitor pops each report when irq_o rises, and the driver waits a bounded number of cycles for it.

// File: rtl/mdm_scan_pkg.sv
package mdm_scan_pkg;

  // control/status word bit positions
  localparam int CSR_RF      = 15;
  localparam int CSR_CF      = 14;
  localparam int CSR_CTSF    = 13;
  localparam int CSR_SRF     = 12;
  localparam int CSR_CLRSCAN = 11;
  localparam int CSR_CLRMUX  = 10;
  localparam int CSR_MAINT   = 9;
  localparam int CSR_STEP    = 8;
  localparam int CSR_DONE    = 7;
  localparam int CSR_IE      = 6;
  localparam int CSR_SE      = 5;
  localparam int CSR_BUSY    = 4;
  localparam int CSR_LINE_W  = 4;

  // line status word bit positions
  localparam int LSR_RING = 7;
  localparam int LSR_CAR  = 6;
  localparam int LSR_CTS  = 5;
  localparam int LSR_SR   = 4;

  // modem inputs of one line; packed order matches flag bits 15..12
  typedef struct packed {
    logic ring;
    logic car;
    logic cts;
    logic sr;
  } mdm_in_t;

  // modem outputs of one line; packed order matches line status bits 3..0
  typedef struct packed {
    logic st;
    logic rts;
    logic dtr;
    logic le;
  } mdm_out_t;

endpackage

// File: rtl/mdm_rst_sync.sv
module mdm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/mdm_line_ctl.sv
module mdm_line_ctl
  import mdm_scan_pkg::*;
#(
  parameter int N_LINES = 16,
  parameter int LINE_W  = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [LINE_W-1:0]  wr_line,
  input  mdm_out_t           wr_val,
  input  logic               clr_all,
  output logic [N_LINES-1:0] le_o,
  output logic [N_LINES-1:0] dtr_o,
  output logic [N_LINES-1:0] rts_o,
  output logic [N_LINES-1:0] st_o
);

  for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line
    mdm_out_t ctl_q;
    mdm_out_t ctl_d;
    logic     ctl_en;

    always_comb begin
      ctl_en = clr_all | (wr_en && (wr_line == LINE_W'(gi)));
      ctl_d  = clr_all ? '0 : wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q <= '0;
      end else if (ctl_en) begin
        ctl_q <= ctl_d;
      end
    end

    assign le_o[gi]  = ctl_q.le;
    assign dtr_o[gi] = ctl_q.dtr;
    assign rts_o[gi] = ctl_q.rts;
    assign st_o[gi]  = ctl_q.st;
  end

endmodule

// File: rtl/mdm_scan_engine.sv
module mdm_scan_engine
  import mdm_scan_pkg::*;
#(
  parameter int N_LINES = 16,
  parameter int LINE_W  = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic               ptr_clr,
  input  logic               shadow_clr,
  input  logic [N_LINES-1:0] ring_i,
  input  logic [N_LINES-1:0] car_i,
  input  logic [N_LINES-1:0] cts_i,
  input  logic [N_LINES-1:0] sr_i,
  output logic               hit,
  output logic [LINE_W-1:0]  hit_line,
  output mdm_in_t            hit_kind
);

  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(N_LINES - 1);

  logic [LINE_W-1:0]             ptr_q;
  logic [LINE_W-1:0]             ptr_d;
  logic                          ptr_en;
  logic [N_LINES-1:0][3:0]       shadow_vec;
  mdm_in_t                       cur;
  mdm_in_t                       seen;

  // compare the visited line against its stored copy
  always_comb begin
    cur      = '{ring: ring_i[ptr_q], car: car_i[ptr_q],
                 cts: cts_i[ptr_q], sr: sr_i[ptr_q]};
    seen     = mdm_in_t'(shadow_vec[ptr_q]);
    hit_kind = cur ^ seen;
    hit      = go && (hit_kind != '0);
    hit_line = ptr_q;
  end

  // scan position: advances on every compare, wraps after the last line
  always_comb begin
    ptr_en = ptr_clr | go;
    if (ptr_clr) begin
      ptr_d = '0;
    end else if (ptr_q == LAST_LINE) begin
      ptr_d = '0;
    end else begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  // per-line copies of the last accepted input values
  for (genvar gi = 0; gi < N_LINES; gi++) begin : g_shadow
    mdm_in_t sh_q;
    mdm_in_t sh_d;
    logic    sh_en;

    always_comb begin
      sh_en = shadow_clr | (hit && (ptr_q == LINE_W'(gi)));
      sh_d  = shadow_clr ? '0 : cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q <= '0;
      end else if (sh_en) begin
        sh_q <= sh_d;
      end
    end

    assign shadow_vec[gi] = sh_q;
  end

endmodule

// File: rtl/mdm_scan_ctrl.sv
module mdm_scan_ctrl
  import mdm_scan_pkg::*;
#(
  parameter int N_LINES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_sel_lsr,
  input  logic [15:0]        bus_wdata,
  output logic [15:0]        bus_rdata,
  input  logic [N_LINES-1:0] ring_i,
  input  logic [N_LINES-1:0] car_i,
  input  logic [N_LINES-1:0] cts_i,
  input  logic [N_LINES-1:0] sr_i,
  output logic [N_LINES-1:0] le_o,
  output logic [N_LINES-1:0] dtr_o,
  output logic [N_LINES-1:0] rts_o,
  output logic [N_LINES-1:0] st_o,
  output logic               irq_o
);

  localparam int LINE_W = (N_LINES < 2) ? 1 : $clog2(N_LINES);

  logic rst_sync_n;

  // control/status state
  logic              ie_q,    ie_d;
  logic              se_q,    se_d;
  logic              maint_q, maint_d;
  logic              step_q,  step_d;
  logic              done_q,  done_d;
  logic              busy_q,  busy_d;
  mdm_in_t           flags_q, flags_d;
  logic [LINE_W-1:0] line_q,  line_d;

  logic              csr_wr;
  logic              lsr_wr;
  logic              scan_go;
  logic              ptr_clr;
  logic              shadow_clr;
  logic              hit;
  logic [LINE_W-1:0] hit_line;
  mdm_in_t           hit_kind;

  logic [N_LINES-1:0] le_w, dtr_w, rts_w, st_w;
  logic [N_LINES-1:0] eff_ring, eff_car, eff_cts, eff_sr;

  mdm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign csr_wr     = bus_wr & ~bus_sel_lsr;
  assign lsr_wr     = bus_wr & bus_sel_lsr;
  assign scan_go    = (se_q | step_q) & ~done_q & ~csr_wr;
  assign ptr_clr    = csr_wr & (bus_wdata[CSR_CLRSCAN] | bus_wdata[CSR_CLRMUX]);
  assign shadow_clr = csr_wr & bus_wdata[CSR_CLRMUX];

  // maintenance loopback of each line's outputs onto its inputs
  always_comb begin
    if (maint_q) begin
      eff_ring = '0;
      eff_car  = dtr_w;
      eff_cts  = rts_w;
      eff_sr   = st_w;
    end else begin
      eff_ring = ring_i;
      eff_car  = car_i;
      eff_cts  = cts_i;
      eff_sr   = sr_i;
    end
  end

  mdm_scan_engine #(.N_LINES(N_LINES), .LINE_W(LINE_W)) u_engine (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .go         (scan_go),
    .ptr_clr    (ptr_clr),
    .shadow_clr (shadow_clr),
    .ring_i     (eff_ring),
    .car_i      (eff_car),
    .cts_i      (eff_cts),
    .sr_i       (eff_sr),
    .hit        (hit),
    .hit_line   (hit_line),
    .hit_kind   (hit_kind)
  );

  mdm_line_ctl #(.N_LINES(N_LINES), .LINE_W(LINE_W)) u_lines (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (lsr_wr),
    .wr_line (line_q),
    .wr_val  (mdm_out_t'(bus_wdata[3:0])),
    .clr_all (shadow_clr),
    .le_o    (le_w),
    .dtr_o   (dtr_w),
    .rts_o   (rts_w),
    .st_o    (st_w)
  );

  // next state of the control/status word; a register write wins over a report
  always_comb begin
    ie_d    = ie_q;
    se_d    = se_q;
    maint_d = maint_q;
    step_d  = step_q;
    done_d  = done_q;
    flags_d = flags_q;
    line_d  = line_q;
    busy_d  = se_q & ~done_q;
    if (csr_wr) begin
      ie_d    = bus_wdata[CSR_IE];
      se_d    = bus_wdata[CSR_SE];
      maint_d = bus_wdata[CSR_MAINT];
      step_d  = bus_wdata[CSR_STEP];
      done_d  = bus_wdata[CSR_DONE] & ~bus_wdata[CSR_CLRSCAN] & ~bus_wdata[CSR_CLRMUX];
      flags_d = '0;
      line_d  = bus_wdata[LINE_W-1:0];
    end else if (hit) begin
      done_d  = 1'b1;
      flags_d = hit_kind;
      line_d  = hit_line;
      step_d  = 1'b0;
    end else if (scan_go) begin
      step_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ie_q    <= 1'b0;
      se_q    <= 1'b0;
      maint_q <= 1'b0;
      step_q  <= 1'b0;
      done_q  <= 1'b0;
      busy_q  <= 1'b0;
      flags_q <= '0;
      line_q  <= '0;
    end else begin
      ie_q    <= ie_d;
      se_q    <= se_d;
      maint_q <= maint_d;
      step_q  <= step_d;
      done_q  <= done_d;
      busy_q  <= busy_d;
      flags_q <= flags_d;
      line_q  <= line_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_sel_lsr) begin
      bus_rdata[LSR_RING] = eff_ring[line_q];
      bus_rdata[LSR_CAR]  = eff_car[line_q];
      bus_rdata[LSR_CTS]  = eff_cts[line_q];
      bus_rdata[LSR_SR]   = eff_sr[line_q];
      bus_rdata[3:0]      = {st_w[line_q], rts_w[line_q], dtr_w[line_q], le_w[line_q]};
    end else begin
      bus_rdata[CSR_RF:CSR_SRF]   = flags_q;
      bus_rdata[CSR_MAINT]        = maint_q;
      bus_rdata[CSR_DONE]         = done_q;
      bus_rdata[CSR_IE]           = ie_q;
      bus_rdata[CSR_SE]           = se_q;
      bus_rdata[CSR_BUSY]         = busy_q;
      bus_rdata[CSR_LINE_W-1:0]   = CSR_LINE_W'(line_q);
    end
  end

  assign le_o  = le_w;
  assign dtr_o = dtr_w;
  assign rts_o = rts_w;
  assign st_o  = st_w;
  assign irq_o = done_q & ie_q;

endmodule

// File: rtl/mdm_scan_ctrl_chk.sv
module mdm_scan_ctrl_chk #(
  parameter int N_LINES = 16,
  parameter int LINE_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic               bus_sel_lsr,
  input logic [15:0]        bus_wdata,
  input logic               irq_o,
  input logic [N_LINES-1:0] le_o,
  input logic [N_LINES-1:0] dtr_o,
  input logic [N_LINES-1:0] rts_o,
  input logic [N_LINES-1:0] st_o,
  input logic               done_q,
  input logic               se_q,
  input logic               step_q,
  input logic               busy_q,
  input logic [3:0]         flags_q,
  input logic [LINE_W-1:0]  line_q
);

  logic csr_wr;
  assign csr_wr = bus_wr && !bus_sel_lsr;

  AST_FLAGS_NEED_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q != 4'd0) |-> done_q);                                         // R2

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !csr_wr) |=> done_q);                                       // R2

  AST_LINE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !csr_wr) |=> $stable(line_q));                              // R2

  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(se_q) |=> !busy_q);                                              // R5

  AST_PROBE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && bus_wdata[7] && bus_wdata[6] && !bus_wdata[11] && !bus_wdata[10]) |=> irq_o); // R8

  AST_CLRMUX_OUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && bus_wdata[10]) |=> (le_o == '0 && dtr_o == '0 && rts_o == '0 && st_o == '0)); // R9

  AST_IDLE_NO_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    (!se_q && !step_q && !csr_wr) |=> !$rose(done_q));                     // R13

endmodule

bind mdm_scan_ctrl mdm_scan_ctrl_chk #(.N_LINES(N_LINES), .LINE_W(LINE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .bus_wr      (bus_wr),
  .bus_sel_lsr (bus_sel_lsr),
  .bus_wdata   (bus_wdata),
  .irq_o       (irq_o),
  .le_o        (le_o),
  .dtr_o       (dtr_o),
  .rts_o       (rts_o),
  .st_o        (st_o),
  .done_q      (done_q),
  .se_q        (se_q),
  .step_q      (step_q),
  .busy_q      (busy_q),
  .flags_q     (flags_q),
  .line_q      (line_q)
);

// File: tb/test_mdm_scan_ctrl.sv
module test_mdm_scan_ctrl;

  localparam int N = 16;

  logic         clk;
  logic         rst_n;
  logic         bus_wr;
  logic         bus_sel_lsr;
  logic [15:0]  bus_wdata;
  logic [15:0]  bus_rdata;
  logic [N-1:0] ring_i, car_i, cts_i, sr_i;
  logic [N-1:0] le_o, dtr_o, rts_o, st_o;
  logic         irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  int mon_cnt = 0;
  bit finished = 0;

  logic [7:0] exp_q[$];   // {line[3:0], flags[3:0]}

  mdm_scan_ctrl #(.N_LINES(N)) i_mdm_scan_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel_lsr(bus_sel_lsr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ring_i(ring_i), .car_i(car_i), .cts_i(cts_i), .sr_i(sr_i),
    .le_o(le_o), .dtr_o(dtr_o), .rts_o(rts_o), .st_o(st_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] data);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel_lsr = sel; bus_wdata = data;
    @(negedge clk);
    bus_wr = 1'b0; bus_sel_lsr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic sel, output logic [15:0] data);
    @(negedge clk);
    bus_sel_lsr = sel;
    #1 data = bus_rdata;
    #1 bus_sel_lsr = 1'b0;
  endtask

  task automatic expect_report(input int line, input logic [3:0] flags);
    exp_q.push_back({line[3:0], flags});
  endtask

  task automatic wait_report(input string req, input int target);
    for (int i = 0; i < 40 && mon_cnt < target; i++) @(negedge clk);
    check(req, mon_cnt, target);
  endtask

  // monitor: pop and compare one expected report per rising irq
  logic irq_prev = 1'b0;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (irq_o && !irq_prev) begin
        if (exp_q.size() == 0) begin
          n_tests++; n_fail++;
          $display("FAIL R2: unexpected report got 0x%0h expected none", bus_rdata);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check("R2 report line", {28'd0, bus_rdata[3:0]}, {28'd0, e[7:4]});
          check("R2 report flags", {28'd0, bus_rdata[15:12]}, {28'd0, e[3:0]});
        end
        mon_cnt++;
      end
      irq_prev = irq_o;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL R2: watchdog expired, got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    bus_wr = 0; bus_sel_lsr = 0; bus_wdata = '0;
    ring_i = '0; car_i = '0; cts_i = '0; sr_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd(1'b0, d); check("R1 csr", {16'd0, d}, 32'h0);
    rd(1'b1, d); check("R1 lsr", {16'd0, d}, 32'h0);
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    check("R1 outputs", {le_o, dtr_o}, 32'h0);

    // R6 / R7: select line 5, write control bits, read status
    wr(1'b0, 16'h0005);
    wr(1'b1, 16'h000B);
    check("R6 le_o", {16'd0, le_o}, 32'h0020);
    check("R6 dtr_o", {16'd0, dtr_o}, 32'h0020);
    check("R6 rts_o", {16'd0, rts_o}, 32'h0000);
    check("R6 st_o", {16'd0, st_o}, 32'h0020);
    ring_i[5] = 1'b1; car_i[5] = 1'b1;
    rd(1'b1, d); check("R7 lsr line5", {16'd0, d}, 32'h00CB);
    wr(1'b0, 16'h0006);
    rd(1'b1, d); check("R7 lsr line6", {16'd0, d}, 32'h0000);
    ring_i[5] = 1'b0; car_i[5] = 1'b0;

    // R13: pin change with scanning off is not reported
    car_i[5] = 1'b1; cts_i[5] = 1'b1;
    repeat (20) @(negedge clk);
    rd(1'b0, d); check("R13 done idle", {31'd0, d[7]}, 32'd0);

    // R2 exact timing: line 5 compared at the 6th edge after the enabling write
    expect_report(5, 4'b0110);
    wr(1'b0, 16'h0060);
    @(negedge clk);
    #1 check("R5 busy while scanning", {31'd0, bus_rdata[4]}, 32'd1);
    repeat (4) @(negedge clk);
    #1 check("R2 no report yet", {31'd0, irq_o}, 32'd0);
    @(negedge clk);
    #1 check("R3 irq with done", {31'd0, irq_o}, 32'd1);
    wait_report("R2 report seen", 1);
    rd(1'b0, d); check("R5 busy clear on done", {31'd0, d[4]}, 32'd0);

    // R12: plain write clears done and flags
    wr(1'b0, 16'h0000);
    rd(1'b0, d); check("R12 done/flags cleared", {16'd0, d & 16'hF080}, 32'h0);
    check("R3 irq low", {31'd0, irq_o}, 32'd0);

    // R4: two lines change together, reported lowest first after scan clear
    ring_i[9] = 1'b1; sr_i[3] = 1'b1;
    expect_report(3, 4'b0001);
    expect_report(9, 4'b1000);
    wr(1'b0, 16'h0860);
    wait_report("R4 first line", 2);
    wr(1'b0, 16'h0060);
    wait_report("R4 second line", 3);

    // R5: busy falls on the second edge after clearing scan enable
    wr(1'b0, 16'h0060);
    @(negedge clk);
    #1 check("R5 busy on", {31'd0, bus_rdata[4]}, 32'd1);
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = 16'h0000;
    @(negedge clk);
    bus_wr = 1'b0;
    #1 check("R5 busy one edge later", {31'd0, bus_rdata[4]}, 32'd1);
    @(negedge clk);
    #1 check("R5 busy two edges later", {31'd0, bus_rdata[4]}, 32'd0);

    // R8: probe write
    expect_report(0, 4'b0000);
    wr(1'b0, 16'h00C0);
    wait_report("R8 probe irq", 4);
    wr(1'b0, 16'h0000);

    // R11: single steps
    car_i[1] = 1'b1;
    wr(1'b0, 16'h0800);
    wr(1'b0, 16'h0140);
    repeat (3) @(negedge clk);
    rd(1'b0, d); check("R11 first step line0 quiet", {31'd0, d[7]}, 32'd0);
    expect_report(1, 4'b0100);
    wr(1'b0, 16'h0140);
    wait_report("R11 second step line1", 5);
    wr(1'b0, 16'h0000);

    // R9: clear multiplexer
    wr(1'b0, 16'h0400);
    check("R9 outputs cleared", {le_o, dtr_o}, 32'h0);
    check("R9 st/rts cleared", {st_o, rts_o}, 32'h0);
    rd(1'b0, d); check("R9 done cleared", {31'd0, d[7]}, 32'd0);
    ring_i = '0; car_i = '0; cts_i = '0; sr_i = '0;

    // R10: maintenance loopback on line 2
    wr(1'b0, 16'h0202);
    wr(1'b1, 16'h000E);
    ring_i[2] = 1'b1;
    rd(1'b1, d); check("R10 loopback lsr", {16'd0, d}, 32'h007E);
    check("R10 dtr_o", {16'd0, dtr_o}, 32'h0004);
    expect_report(2, 4'b0111);
    wr(1'b0, 16'h0A60);
    wait_report("R10 loopback report", 6);
    wr(1'b0, 16'h0000);
    repeat (3) @(negedge clk);
    check("R2 queue drained", exp_q.size(), 32'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule